// File: doc/BRIEF.md
# Post-Result Predicated Vector Writeback Sequencer

This block steps a vector operation through element indices 0 to VL-1, one element per clock. For each element it presents the index to an upstream element ALU. It takes back the signed result and an overflow flag and forms a 4-bit condition field from them. It then decides, for that element alone, whether the condition field goes to a condition-field array and whether the result goes to an integer register array.

There are two layers of gating. The first is the predicate mask: an element whose mask bit is clear produces no write at all. The second applies to active elements. The result write passes a branch-style test on the element's own condition field. The test names one condition bit and the value that bit must hold, and it acts as a second predicate ANDed with the mask. The condition field can still be written even when the result is not. A compare-only mode writes condition fields and never writes results. Elements never depend on one another and a run never stops early.

Top module: `pred_wb_seq`

## Requirements
- R1: An element whose bit in the latched predicate mask is 0 produces neither a condition-field write nor a result write.
- R2: The condition field is packed as bit 3 = less than zero (result sign bit set), bit 2 = greater than zero, bit 1 = equal to zero, bit 0 = the overflow flag returned with the result. It appears on `cr_data_o` in the cycle its write is issued.
- R3: When `rc_i` or `rc1_i` was set at start, every active element writes its condition field. The write is issued in the cycle after that element's index was presented.
- R4: When `rc1_i` was set at start, no result write is issued for any element.
- R5: When `rc1_i` is clear, an active element writes its result only if condition-field bit (3 - `sel_i`) equals `pol_i`. The selector codes are 0 = lt, 1 = gt, 2 = eq and 3 = so. The eight tests are lt/ge, gt/le, eq/ne and so/ns, each with `pol_i` = 1/0.
- R6: When both `rc_i` and `rc1_i` were clear at start, no condition-field write is issued.
- R7: Write addresses are the latched base plus the element index, modulo 2^AW. `rf_data_o` carries the element's unmodified result.
- R8: Index k (0 to VL-1, in order) is presented with `elem_vld_o` high in the k+1-th cycle after the start edge. A VL above MAX_VL is treated as MAX_VL. `done_o` pulses for one cycle right after the last index. With VL = 0, `done_o` pulses in the cycle after the start edge and no writes occur.
- R9: A start request received while a run is in progress is ignored, and the run continues with its original configuration.
- R10: After reset the block is idle: `busy_o`, `done_o`, `elem_vld_o` and both write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run; configuration sampled on this edge |
| vl_i | input | VLW | Vector length |
| mask_i | input | MAX_VL | Predicate mask, bit k for element k |
| rc_i | input | 1 | Record condition fields |
| rc1_i | input | 1 | Compare-only mode |
| sel_i | input | 2 | Condition bit tested for result write |
| pol_i | input | 1 | Value the tested bit must hold |
| cr_base_i | input | AW | Condition-array base index |
| rf_base_i | input | AW | Result-array base index |
| elem_idx_o | output | IW | Element index requested from the ALU |
| elem_vld_o | output | 1 | Element index valid this cycle |
| res_i | input | XLEN | ALU result for `elem_idx_o` |
| ovf_i | input | 1 | ALU overflow for `elem_idx_o` |
| cr_we_o | output | 1 | Condition-array write enable |
| cr_addr_o | output | AW | Condition-array write index |
| cr_data_o | output | 4 | Condition field |
| rf_we_o | output | 1 | Result-array write enable |
| rf_addr_o | output | AW | Result-array write index |
| rf_data_o | output | XLEN | Result written |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The index for element k is due k+1 cycles after the start edge. Both write strobes for that element are due one cycle later, in the same cycle as the next index, and `done_o` lines up with the writes of the last element. The bench drives inputs just after each rising edge. It compares every output at the falling edge against a behavioural model, and that model advances its own expected state from the inputs it saw in that cycle. Because of this, every index, strobe, address and data value is checked in exactly the cycle it is due, including the cycles in which a write must be absent.

// File: rtl/pred_wb_pkg.sv
package pred_wb_pkg;

    // Condition-field bit positions (field is {lt, gt, eq, so})
    localparam int CF_LT = 3;
    localparam int CF_GT = 2;
    localparam int CF_EQ = 1;
    localparam int CF_SO = 0;

    typedef enum logic [1:0] {
        SEL_LT = 2'd0,
        SEL_GT = 2'd1,
        SEL_EQ = 2'd2,
        SEL_SO = 2'd3
    } cond_sel_e;

    typedef logic [3:0] cond_field_t;

endpackage

// File: rtl/pwb_cond_gen.sv
module pwb_cond_gen
    import pred_wb_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] res_i,
    input  logic            ovf_i,
    output cond_field_t     cf_o
);
    logic neg;
    logic zero;

    always_comb begin
        neg      = res_i[XLEN-1];
        zero     = (res_i == '0);
        cf_o     = '0;
        cf_o[CF_LT] = neg;
        cf_o[CF_EQ] = zero;
        cf_o[CF_GT] = !neg && !zero;
        cf_o[CF_SO] = ovf_i;
    end
endmodule

// File: rtl/pwb_cond_test.sv
module pwb_cond_test
    import pred_wb_pkg::*;
(
    input  cond_field_t cf_i,
    input  logic [1:0]  sel_i,
    input  logic        pol_i,
    output logic        pass_o
);
    logic picked;

    always_comb begin
        unique case (cond_sel_e'(sel_i))
            SEL_LT:  picked = cf_i[CF_LT];
            SEL_GT:  picked = cf_i[CF_GT];
            SEL_EQ:  picked = cf_i[CF_EQ];
            default: picked = cf_i[CF_SO];
        endcase
        pass_o = (picked == pol_i);
    end
endmodule

// File: rtl/pwb_elem_gate.sv
module pwb_elem_gate (
    input  logic active_i,
    input  logic rc_i,
    input  logic rc1_i,
    input  logic pass_i,
    output logic cr_en_o,
    output logic rf_en_o
);
    always_comb begin
        cr_en_o = active_i && (rc_i || rc1_i);
        rf_en_o = active_i && !rc1_i && pass_i;
    end
endmodule

// File: rtl/pred_wb_seq.sv
module pred_wb_seq
    import pred_wb_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int MAX_VL = 16,
    parameter int AW     = 7,
    parameter int IW     = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
    parameter int VLW    = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VLW-1:0]    vl_i,
    input  logic [MAX_VL-1:0] mask_i,
    input  logic              rc_i,
    input  logic              rc1_i,
    input  logic [1:0]        sel_i,
    input  logic              pol_i,
    input  logic [AW-1:0]     cr_base_i,
    input  logic [AW-1:0]     rf_base_i,
    output logic [IW-1:0]     elem_idx_o,
    output logic              elem_vld_o,
    input  logic [XLEN-1:0]   res_i,
    input  logic              ovf_i,
    output logic              cr_we_o,
    output logic [AW-1:0]     cr_addr_o,
    output logic [3:0]        cr_data_o,
    output logic              rf_we_o,
    output logic [AW-1:0]     rf_addr_o,
    output logic [XLEN-1:0]   rf_data_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [VLW-1:0] VL_CAP = VLW'(MAX_VL);

    typedef struct packed {
        logic              busy;
        logic [IW-1:0]     idx;
        logic [VLW-1:0]    vl;
        logic [MAX_VL-1:0] mask;
        logic              rc;
        logic              rc1;
        logic [1:0]        sel;
        logic              pol;
        logic [AW-1:0]     crb;
        logic [AW-1:0]     rfb;
        logic              cr_we;
        logic [AW-1:0]     cr_addr;
        cond_field_t       cr_data;
        logic              rf_we;
        logic [AW-1:0]     rf_addr;
        logic [XLEN-1:0]   rf_data;
        logic              done;
    } seq_state_t;

    seq_state_t s_d, s_q;

    cond_field_t cf_w;
    logic        pass_w;
    logic        active_w;
    logic        cr_en_w;
    logic        rf_en_w;
    logic        last_w;

    pwb_cond_gen #(.XLEN(XLEN)) u_cond_gen (
        .res_i (res_i),
        .ovf_i (ovf_i),
        .cf_o  (cf_w)
    );

    pwb_cond_test u_cond_test (
        .cf_i   (cf_w),
        .sel_i  (s_q.sel),
        .pol_i  (s_q.pol),
        .pass_o (pass_w)
    );

    pwb_elem_gate u_elem_gate (
        .active_i (active_w),
        .rc_i     (s_q.rc),
        .rc1_i    (s_q.rc1),
        .pass_i   (pass_w),
        .cr_en_o  (cr_en_w),
        .rf_en_o  (rf_en_w)
    );

    always_comb begin
        active_w = s_q.busy && s_q.mask[s_q.idx];
        last_w   = (VLW'(s_q.idx) + VLW'(1)) == s_q.vl;

        s_d       = s_q;
        s_d.cr_we = 1'b0;
        s_d.rf_we = 1'b0;
        s_d.done  = 1'b0;

        if (s_q.busy) begin
            s_d.cr_we   = cr_en_w;
            s_d.rf_we   = rf_en_w;
            s_d.cr_addr = s_q.crb + AW'(s_q.idx);
            s_d.rf_addr = s_q.rfb + AW'(s_q.idx);
            s_d.cr_data = cf_w;
            s_d.rf_data = res_i;
            if (last_w) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.idx  = '0;
            end else begin
                s_d.idx  = s_q.idx + IW'(1);
            end
        end else if (start_i) begin
            s_d.vl   = (vl_i > VL_CAP) ? VL_CAP : vl_i;
            s_d.mask = mask_i;
            s_d.rc   = rc_i;
            s_d.rc1  = rc1_i;
            s_d.sel  = sel_i;
            s_d.pol  = pol_i;
            s_d.crb  = cr_base_i;
            s_d.rfb  = rf_base_i;
            s_d.idx  = '0;
            if (vl_i == '0) begin
                s_d.done = 1'b1;
            end else begin
                s_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign elem_idx_o = s_q.idx;
    assign elem_vld_o = s_q.busy;
    assign cr_we_o    = s_q.cr_we;
    assign cr_addr_o  = s_q.cr_addr;
    assign cr_data_o  = s_q.cr_data;
    assign rf_we_o    = s_q.rf_we;
    assign rf_addr_o  = s_q.rf_addr;
    assign rf_data_o  = s_q.rf_data;
    assign busy_o     = s_q.busy;
    assign done_o     = s_q.done;

    AST_MASKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !s_q.mask[s_q.idx]) |=> (!cr_we_o && !rf_we_o)); // R1

    AST_CF_ONE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we_o |-> $onehot(cr_data_o[3:1])); // R2

    AST_CR_ON_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.mask[s_q.idx] && (s_q.rc || s_q.rc1)) |=> cr_we_o); // R3

    AST_RC1_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.rc1) |=> !rf_we_o); // R4

    AST_RF_TEST_PASSED: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (cr_data_o[3 - s_q.sel] == s_q.pol)); // R5

    AST_NO_CR_WITHOUT_RC: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !s_q.rc && !s_q.rc1) |=> !cr_we_o); // R6

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && last_w) |=> (done_o && !busy_o)); // R8

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && start_i) |=> ($stable(s_q.mask) && $stable(s_q.sel) && $stable(s_q.rfb))); // R9

endmodule

// File: tb/tb_pred_wb_seq.sv
`timescale 1ns/1ps
module tb_pred_wb_seq;
    localparam int XLEN   = 32;
    localparam int MAX_VL = 16;
    localparam int AW     = 7;
    localparam int IW     = 4;
    localparam int VLW    = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [VLW-1:0]    vl_i = '0;
    logic [MAX_VL-1:0] mask_i = '0;
    logic              rc_i = 1'b0, rc1_i = 1'b0, pol_i = 1'b0;
    logic [1:0]        sel_i = '0;
    logic [AW-1:0]     cr_base_i = '0, rf_base_i = '0;
    logic [IW-1:0]     elem_idx_o;
    logic              elem_vld_o;
    logic [XLEN-1:0]   res_i;
    logic              ovf_i;
    logic              cr_we_o, rf_we_o, busy_o, done_o;
    logic [AW-1:0]     cr_addr_o, rf_addr_o;
    logic [3:0]        cr_data_o;
    logic [XLEN-1:0]   rf_data_o;

    always #2.5 clk = ~clk;

    pred_wb_seq #(.XLEN(XLEN), .MAX_VL(MAX_VL), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i), .mask_i(mask_i),
        .rc_i(rc_i), .rc1_i(rc1_i), .sel_i(sel_i), .pol_i(pol_i),
        .cr_base_i(cr_base_i), .rf_base_i(rf_base_i),
        .elem_idx_o(elem_idx_o), .elem_vld_o(elem_vld_o), .res_i(res_i), .ovf_i(ovf_i),
        .cr_we_o(cr_we_o), .cr_addr_o(cr_addr_o), .cr_data_o(cr_data_o),
        .rf_we_o(rf_we_o), .rf_addr_o(rf_addr_o), .rf_data_o(rf_data_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    // Element ALU model
    logic [XLEN-1:0] vals [MAX_VL];
    logic            ovfs [MAX_VL];
    assign res_i = vals[elem_idx_o];
    assign ovf_i = ovfs[elem_idx_o];

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model state
    int          m_busy, m_idx, m_vl;
    logic [MAX_VL-1:0] m_mask;
    logic        m_rc, m_rc1, m_pol;
    int          m_sel, m_crb, m_rfb;
    int          e_busy, e_done, e_crwe, e_rfwe, e_craddr, e_rfaddr, e_idx, e_vld;
    logic [3:0]  e_cf;
    logic [XLEN-1:0] e_res;
    string       t_cr, t_rf;

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] ref_cf(input logic [XLEN-1:0] v, input logic o);
        int s;
        s = $signed(v);
        return {s < 0, s > 0, s == 0, o};
    endfunction

    always @(negedge clk) begin
        // compare this cycle
        chk(rst_n ? "R8 busy" : "R10 busy", busy_o, e_busy);
        chk(rst_n ? "R8 done" : "R10 done", done_o, e_done);
        chk(rst_n ? "R8 vld" : "R10 vld", elem_vld_o, e_vld);
        if (e_vld) chk("R8 idx", elem_idx_o, e_idx);
        chk(t_cr, cr_we_o, e_crwe);
        chk(t_rf, rf_we_o, e_rfwe);
        if (e_crwe) begin
            chk("R7 cr_addr", cr_addr_o, e_craddr);
            chk("R2 cf", cr_data_o, e_cf);
        end
        if (e_rfwe) begin
            chk("R7 rf_addr", rf_addr_o, e_rfaddr);
            chk("R7 rf_data", rf_data_o, e_res);
        end
        // advance model
        e_crwe = 0; e_rfwe = 0; e_done = 0;
        t_cr = "R10 cr_we"; t_rf = "R10 rf_we";
        if (!rst_n) begin
            m_busy = 0; m_idx = 0;
        end else if (m_busy) begin
            if (!m_mask[m_idx]) begin
                t_cr = "R1 cr_we"; t_rf = "R1 rf_we";
            end else begin
                e_cf  = ref_cf(vals[m_idx], ovfs[m_idx]);
                e_res = vals[m_idx];
                e_crwe = (m_rc || m_rc1);
                t_cr = e_crwe ? "R3 cr_we" : "R6 cr_we";
                e_rfwe = !m_rc1 && (e_cf[3 - m_sel] == m_pol);
                t_rf = m_rc1 ? "R4 rf_we" : "R5 rf_we";
            end
            e_craddr = (m_crb + m_idx) % (1 << AW);
            e_rfaddr = (m_rfb + m_idx) % (1 << AW);
            if (m_idx == m_vl - 1) begin
                m_busy = 0; m_idx = 0; e_done = 1;
            end else m_idx++;
        end else if (start_i) begin
            m_vl = (vl_i > MAX_VL) ? MAX_VL : int'(vl_i);
            m_mask = mask_i; m_rc = rc_i; m_rc1 = rc1_i;
            m_sel = sel_i; m_pol = pol_i; m_crb = cr_base_i; m_rfb = rf_base_i;
            m_idx = 0;
            if (m_vl == 0) e_done = 1; else m_busy = 1;
        end
        if (!start_i && !m_busy) t_cr = (t_cr == "R10 cr_we") ? "R9 cr_we" : t_cr;
        e_busy = m_busy; e_vld = m_busy; e_idx = m_idx;
    end

    task automatic fill(input int kind);
        for (int i = 0; i < MAX_VL; i++) begin
            case ((i + kind) % 4)
                0: vals[i] = '0;
                1: vals[i] = -(i + 1);
                2: vals[i] = i * 1000 + 7;
                default: vals[i] = 32'h8000_0000 + i;
            endcase
            ovfs[i] = ((i + kind) % 3) == 0;
        end
    endtask

    task automatic run_op(input int vl, input logic [MAX_VL-1:0] m, input logic rc,
                          input logic rc1, input int sel, input logic pol,
                          input int crb, input int rfb, input int poke);
        @(posedge clk); #1;
        start_i = 1; vl_i = VLW'(vl); mask_i = m; rc_i = rc; rc1_i = rc1;
        sel_i = 2'(sel); pol_i = pol; cr_base_i = AW'(crb); rf_base_i = AW'(rfb);
        @(posedge clk); #1;
        start_i = 0;
        for (int c = 0; c < MAX_VL + 3; c++) begin
            if (poke != 0 && c == 2) begin
                // R9: start while busy with a different configuration
                start_i = 1; mask_i = ~m; rc1_i = ~rc1; sel_i = ~sel_i; rf_base_i = 7'h55;
            end else start_i = 0;
            @(posedge clk); #1;
        end
        start_i = 0;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        e_busy = 0; e_done = 0; e_vld = 0; e_idx = 0; e_crwe = 0; e_rfwe = 0;
        e_craddr = 0; e_rfaddr = 0; e_cf = '0; e_res = '0;
        m_busy = 0; m_idx = 0; m_vl = 0; m_mask = '0; m_rc = 0; m_rc1 = 0;
        m_pol = 0; m_sel = 0; m_crb = 0; m_rfb = 0;
        t_cr = "R10 cr_we"; t_rf = "R10 rf_we";
        fill(0);
        repeat (4) @(posedge clk);          // R10 reset state compared each cycle
        #1 rst_n = 1;
        // R3 R5 R2: record, eq test, full mask
        run_op(8, 16'hFFFF, 1, 0, 2, 1, 10, 20, 0);
        // R4 R1: compare-only, sparse mask
        fill(1);
        run_op(12, 16'hA5C3, 0, 1, 0, 1, 3, 40, 0);
        // R6 R5: no record, ge test
        fill(2);
        run_op(9, 16'h7FFE, 0, 0, 0, 0, 0, 60, 0);
        // R5: all eight tests
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 2; p++) begin
                fill(s + p);
                run_op(MAX_VL, 16'hF0FF, 1, 0, s, p[0], 4 * s, 8 * p, 0);
            end
        // R8: zero length, over-length clamp; R7 address wrap
        run_op(0, 16'hFFFF, 1, 0, 0, 1, 0, 0, 0);
        fill(3);
        run_op(20, 16'hFFFF, 1, 0, 1, 0, 120, 125, 0);
        // R9: start during a run ignored
        run_op(10, 16'h03FF, 1, 0, 3, 1, 30, 50, 1);
        repeat (4) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule